// File: doc/BRIEF.md
# Countdown Interval Timer with Register Bus

This block is a down-counting timer that runs on the system clock and raises an interrupt line when its count runs out. Software drives it over a simple synchronous register bus with 16-bit data. It can write the period as two halves, preload the live count, start and stop it, pick single-run or repeating operation, and clear the timeout flag. All times are given in clock cycles, so an 80 MHz clock needs a value of 80000 for a 1 ms interval.

The counter reloads from the period at every expiry, in both modes. A single run therefore starts from whatever count was preloaded, and every later run starts from the period. The period's reset value and whether software may change it are build-time parameters.

Register offsets: 0 status, 1 control, 2 period low half, 3 period high half, 4 count low half, 5 count high half.

Top module: `tmr_interval`

## Requirements
- R1: After reset, status and control read 0, the period reads PERIOD_RESET, the count reads PERIOD_RESET, and irq is low.
- R2: Control write bits are: bit 0 interrupt enable, bit 1 repeating mode, bit 2 start, and bit 3 stop. Stop wins over start in the same write. A control read returns the enable in bit 0 and the mode in bit 1.
- R3: When the timer is started with a count of N≥1, the timeout flag (status bit 0) is set on the N-th rising edge after the edge that accepts the start write.
- R4: In single-run mode, the running bit (status bit 1) clears at expiry.
- R5: At every expiry the count reloads from the period, whatever the mode.
- R6: The timeout flag stays set until any write to status clears it. irq is high exactly when the flag and the enable are both set.
- R7: When the period is writable, a write to offset 2 or 3 updates that half of the period, loads the count with the new full period, and stops the timer.
- R8: In repeating mode, the timer keeps running and expires again every P cycles, where P is the period.
- R9: While stopped, the count holds its value.
- R10: With the enable at 0, an expiry sets the flag but leaves irq low.
- R11: A write to offset 4 or 5 sets that half of the live count. A read of offset 4 returns the live low half and latches the whole count, so a following read of offset 5 returns the matching high half. Read data appears one cycle after the read strobe.
- R12: When the period is not writable, writes to offsets 2 and 3 change neither the period nor the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | CNT_W/2 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | CNT_W/2 | Read data, valid one cycle after bus_rd |
| irq | output | 1 | Timeout interrupt |

## Verification
The bench builds two copies of the block on one shared bus, both with a 32-bit count and a reset period of 20. The first copy has a writable period and the second does not. The short reset period keeps runs from reset brief. The shared bus shows in one read that a period write stops the first copy and leaves the second running. Random preload and period values of a few hundred cycles or less make the expiry timing checkable cycle by cycle, and a two-half preload reaches the upper count half.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register offsets; control bit positions are the software-visible encoding
  localparam int REG_STAT   = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_PER_LO = 2;
  localparam int REG_PER_HI = 3;
  localparam int REG_CNT_LO = 4;
  localparam int REG_CNT_HI = 5;

  localparam int CB_IE   = 0;
  localparam int CB_REP  = 1;
  localparam int CB_GO   = 2;
  localparam int CB_HALT = 3;
endpackage

// File: rtl/tmr_period.sv
module tmr_period #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RESET_VAL = '0,
  parameter bit WRITABLE = 1'b1,
  localparam int HW = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [HW-1:0]    wdata,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] per_d
);
  generate
    if (WRITABLE) begin : g_rw
      logic [CNT_W-1:0] per_r;
      always_comb begin
        per_d = per_r;
        if (wr_lo) per_d[HW-1:0]     = wdata;
        if (wr_hi) per_d[CNT_W-1:HW] = wdata;
      end
      always_ff @(posedge clk) begin
        if (rst) per_r <= RESET_VAL;
        else     per_r <= per_d;
      end
      assign per_q = per_r;
    end else begin : g_ro
      logic unused_ro;
      assign unused_ro = ^{clk, rst, wr_lo, wr_hi, wdata};
      assign per_q = RESET_VAL;
      assign per_d = RESET_VAL;
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] RESET_VAL = '0,
  localparam int HW = CNT_W / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load_full,
  input  logic [CNT_W-1:0] load_val,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [HW-1:0]    wdata,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a count of 0 or 1 ends the run on this edge
  assign expire = run && (cnt_q <= ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (run) cnt_d = expire ? reload_val : cnt_q - ONE;
    if (wr_lo) cnt_d[HW-1:0]     = wdata;
    if (wr_hi) cnt_d[CNT_W-1:HW] = wdata;
    if (load_full) cnt_d = load_val;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= RESET_VAL;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [CNT_W-1:0] PERIOD_RESET = 32'd20,
  parameter bit PERIOD_WRITABLE = 1'b1,
  localparam int HW = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [HW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [HW-1:0]     bus_rdata,
  output logic              irq
);
  logic wr_stat, wr_ctrl, wr_plo, wr_phi, wr_clo, wr_chi, per_load;
  logic run_q, run_d, to_q, ie_q, rep_q, expire;
  logic [CNT_W-1:0] per_q, per_d, cnt_q, snap_q;
  logic [HW-1:0] rdata_q;

  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign wr_plo  = bus_wr && (bus_addr == ADDR_W'(REG_PER_LO));
  assign wr_phi  = bus_wr && (bus_addr == ADDR_W'(REG_PER_HI));
  assign wr_clo  = bus_wr && (bus_addr == ADDR_W'(REG_CNT_LO));
  assign wr_chi  = bus_wr && (bus_addr == ADDR_W'(REG_CNT_HI));
  assign per_load = PERIOD_WRITABLE && (wr_plo || wr_phi);

  tmr_period #(.CNT_W(CNT_W), .RESET_VAL(PERIOD_RESET), .WRITABLE(PERIOD_WRITABLE)) u_per (
    .clk(clk), .rst(rst), .wr_lo(wr_plo), .wr_hi(wr_phi), .wdata(bus_wdata),
    .per_q(per_q), .per_d(per_d)
  );

  tmr_counter #(.CNT_W(CNT_W), .RESET_VAL(PERIOD_RESET)) u_cnt (
    .clk(clk), .rst(rst), .run(run_q), .load_full(per_load), .load_val(per_d),
    .wr_lo(wr_clo), .wr_hi(wr_chi), .wdata(bus_wdata), .reload_val(per_q),
    .cnt(cnt_q), .expire(expire)
  );

  always_comb begin
    run_d = run_q;
    if (expire && !rep_q) run_d = 1'b0;
    if (wr_ctrl && bus_wdata[CB_GO])   run_d = 1'b1;
    if (wr_ctrl && bus_wdata[CB_HALT]) run_d = 1'b0;
    if (per_load) run_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      to_q  <= 1'b0;
      ie_q  <= 1'b0;
      rep_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (expire)       to_q <= 1'b1;
      else if (wr_stat) to_q <= 1'b0;
      if (wr_ctrl) begin
        ie_q  <= bus_wdata[CB_IE];
        rep_q <= bus_wdata[CB_REP];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      snap_q  <= PERIOD_RESET;
    end else if (bus_rd) begin
      unique case (int'(bus_addr))
        REG_STAT:   rdata_q <= {{(HW-2){1'b0}}, run_q, to_q};
        REG_CTRL:   rdata_q <= {{(HW-2){1'b0}}, rep_q, ie_q};
        REG_PER_LO: rdata_q <= per_q[HW-1:0];
        REG_PER_HI: rdata_q <= per_q[CNT_W-1:HW];
        REG_CNT_LO: begin
          rdata_q <= cnt_q[HW-1:0];
          snap_q  <= cnt_q;
        end
        REG_CNT_HI: rdata_q <= snap_q[CNT_W-1:HW];
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign irq = to_q & ie_q;
endmodule

// File: rtl/tmr_interval_chk.sv
module tmr_interval_chk #(
  parameter int CNT_W = 32,
  parameter int ADDR_W = 3,
  parameter bit PER_WR = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic              run,
  input logic              to,
  input logic              rep,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  per
);
  logic at_end;
  assign at_end = run && (cnt < CNT_W'(2));

  AST_FLAG_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(to) |-> $past(run)); // R3
  AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (rst)
    at_end && !rep && !wr |=> !run); // R4
  AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (rst)
    at_end && !wr |=> cnt == $past(per)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    to && !(wr && addr == ADDR_W'(0)) |=> to); // R6
  AST_PERIOD_WR_STOPS: assert property (@(posedge clk) disable iff (rst)
    PER_WR && wr && (addr == ADDR_W'(2) || addr == ADDR_W'(3)) |=> !run); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !run && !wr |=> $stable(cnt)); // R9
endmodule

bind tmr_interval tmr_interval_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PER_WR(PERIOD_WRITABLE)) u_chk (
  .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .run(run_q), .to(to_q),
  .rep(rep_q), .cnt(cnt_q), .per(per_q)
);

// File: tb/sim_tmr_interval.sv
module sim_tmr_interval;
  localparam logic [31:0] PRST = 32'd20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rd0, rd1;
  logic        irq0, irq1;
  int n_chk = 0, n_bad = 0;
  logic [15:0] v0, v1, va;
  int n, p;

  tmr_interval #(.CNT_W(32), .ADDR_W(3), .PERIOD_RESET(PRST), .PERIOD_WRITABLE(1'b1)) u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wd),
    .bus_rd(rd), .bus_rdata(rd0), .irq(irq0));
  tmr_interval #(.CNT_W(32), .ADDR_W(3), .PERIOD_RESET(PRST), .PERIOD_WRITABLE(1'b0)) u1 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wd),
    .bus_rd(rd), .bus_rdata(rd1), .irq(irq1));

  function automatic logic [15:0] lo16(int v); return v[15:0]; endfunction
  function automatic logic [15:0] stat_word(bit running, bit flag);
    return {14'd0, running, flag};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // both tasks start and end at a falling edge
  task automatic bwr(int a, int d);
    addr = a[2:0]; wd = d[15:0]; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic brd(int a);
    addr = a[2:0]; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v0 = rd0; v1 = rd1;
  endtask

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq0, 0);
    brd(0); chk("R1 status", v0, 0);
    brd(1); chk("R1 control", v0, 0);
    brd(2); chk("R1 period lo", v0, lo16(PRST));
    brd(3); chk("R1 period hi", v0, 0);
    brd(4); chk("R1 count lo", v0, lo16(PRST));
    brd(5); chk("R1 count hi", v0, 0);

    // R3 R4 R5 R6: single runs from random preloads
    for (int i = 0; i < 6; i++) begin
      n = 3 + int'($urandom % 200);
      bwr(4, n); bwr(5, 0);
      bwr(1, 5);
      idle(n - 1); chk("R3 irq before expiry", irq0, 0);
      idle(1);     chk("R3 irq at expiry", irq0, 1);
      brd(0); chk("R4 single run stopped", v0, stat_word(0, 1));
      brd(4); chk("R5 reload from period", v0, lo16(PRST));
      bwr(0, 0); chk("R6 flag cleared", irq0, 0);
      brd(0); chk("R6 status clear", v0, 0);
    end

    // R7 R12: period write stops u0 only, u1 keeps period and runs on
    bwr(4, 1000); bwr(1, 4);
    bwr(2, 55);
    brd(0); chk("R7 period write stops", v0[1], 0);
    chk("R12 fixed period keeps running", v1[1], 1);
    brd(2); chk("R7 period lo", v0, 55);
    chk("R12 fixed period unchanged", v1, lo16(PRST));
    bwr(1, 8);

    // R7 R8: repeating mode with random period
    p = 5 + int'($urandom % 50);
    bwr(2, p); bwr(3, 0);
    brd(4); chk("R7 count loaded with period", v0, lo16(p));
    brd(0); chk("R7 stopped after period write", v0[1], 0);
    bwr(1, 7);
    idle(p - 1); chk("R8 first irq early", irq0, 0);
    idle(1);     chk("R8 first irq", irq0, 1);
    bwr(0, 0);   chk("R6 clear in repeat", irq0, 0);
    idle(p - 2); chk("R8 second irq early", irq0, 0);
    idle(1);     chk("R8 second irq", irq0, 1);
    brd(0); chk("R8 still running", v0, stat_word(1, 1));

    // R9 R2: stop holds count; stop beats start
    bwr(1, 9);
    brd(4); va = v0;
    idle(7);
    brd(4); chk("R9 count held", v0, va);
    bwr(1, 12);
    brd(0); chk("R2 stop wins", v0[1], 0);
    bwr(1, 3);
    brd(1); chk("R2 control readback", v0, 3);

    // R10: expiry with interrupt disabled
    bwr(0, 0);
    bwr(4, 4); bwr(5, 0); bwr(1, 4);
    idle(4);
    chk("R10 irq masked", irq0, 0);
    brd(0); chk("R10 flag set", v0, stat_word(0, 1));
    bwr(1, 1); chk("R6 irq follows enable", irq0, 1);
    bwr(0, 0);

    // R11: 32-bit preload through both halves
    bwr(4, 16'h0002); bwr(5, 16'h0001);
    brd(4); chk("R11 count lo", v0, 16'h0002);
    brd(5); chk("R11 count hi", v0, 16'h0001);

    summary();
  end
endmodule